// File: doc/BRIEF.md
# Shadowed DAC Code Register File

This block is the register file that sits in front of one 12-bit DAC channel. A 16-bit register bus (address, write data, write enable, byte strobes, combinational read data) gives software access to a revision word and the channel's settings: control, active code, shadow code, output enable, lock and trim. Software writes the next code into the shadow register. The block then moves it into the active code that drives the converter. It does this either on every clock or only when one chosen periodic sync pulse fires, so a code change can line up with a control period.

Writes to the settings registers are guarded in two ways. First, a protected-write enable input must be high. Second, a keyed lock register holds write-once bits. Each bit freezes one of control, shadow code or output enable until the next reset. A write that is refused for either reason is dropped, and a one-cycle error pulse is raised. The block drives the active code, output enable, gain select, reference select and trim value to the analog macro, which is outside this block.

Top module: `dacreg_top`

## Requirements
- R1: After reset every register field is zero, every output is zero, and offset 0 reads the REV_ID parameter in bits 7:0.
- R2: Reads are combinational on the address. The layouts are:
  - offset 1 (control): sync select in bits 7:4, load-on-sync in bit 2, gain-of-two in bit 1, alternate reference in bit 0.
  - offset 2: active code in bits 11:0.
  - offset 3: shadow code in bits 11:0.
  - offset 4: output enable in bit 0.
  - offset 5: lock bits in 2:0.
  - offset 6: trim in bits 7:0 and a spare read/write field in bits 11:8.
  - All other bits, and offset 7, read zero.
- R3: With load-on-sync clear, the active code takes the shadow register value at every clock edge, so a shadow write shows on the active code one cycle after it lands.
- R4: With load-on-sync set, the active code changes only at an edge where sync_pulse[sync select] is high, and it takes the shadow value held before that edge.
- R5: With load-on-sync set and the sync select at or above NUM_SYNC, the active code never changes.
- R6: If a shadow write and a load event fall on the same edge, the active code takes the old shadow value, and the new one is loaded at the next event.
- R7: A write to offset 5 changes the lock bits only if bits 15:12 carry 0xA, both byte strobes are set and the protected-write enable is high. Any other write leaves them as they were.
- R8: Lock bits only ever set, and writing 0 does not clear them:
  - lock bit 0 blocks control writes.
  - lock bit 1 blocks shadow writes.
  - lock bit 2 blocks output-enable writes.
- R9: Control, output enable, lock and trim accept writes only while prot_en is high. The shadow register does not need it.
- R10: For registers other than lock, bus_be[0] gates write bits 7:0 and bus_be[1] gates write bits 15:8.
- R11: A write refused because of prot_en or a lock bit makes bus_err high for exactly the cycle after its edge. A wrong key, a partial lock write, or a write to a read-only offset raises no error.
- R12: dac_out_en, dac_gain2, dac_ref_alt and dac_trim follow the output-enable bit, control bit 1, control bit 0 and trim bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_be | input | 2 | Byte strobes for the write |
| bus_rdata | output | 16 | Read data for bus_addr |
| prot_en | input | 1 | Protected-write enable |
| sync_pulse | input | NUM_SYNC | Periodic sync pulses, one per source |
| dac_code | output | 12 | Active code to the converter |
| dac_out_en | output | 1 | Output buffer enable |
| dac_gain2 | output | 1 | Gain-of-two select |
| dac_ref_alt | output | 1 | Alternate reference select |
| dac_trim | output | 8 | Offset trim value |
| bus_err | output | 1 | One-cycle pulse on a refused write |

## Verification
The bench builds the block with NUM_SYNC = 6 and REV_ID = 8'h5C. With six sources, a 4-bit select has values 6 to 15 with no source behind them. This puts the no-load path of R5 within reach of both directed and random stimulus. A non-zero revision makes the offset-0 read distinguishable from a reserved or broken decode.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

    localparam int BUS_W  = 16;
    localparam int BE_W   = BUS_W / 8;
    localparam int ADR_W  = 3;
    localparam int CODE_W = 12;
    localparam int SEL_W  = 4;
    localparam int TRIM_W = 8;
    localparam int SPARE_W = 4;
    localparam int LOCK_W = 3;
    localparam int KEY_W  = 4;
    localparam logic [KEY_W-1:0] LOCK_KEY = 4'hA;

    localparam int LK_CTL = 0;
    localparam int LK_SHD = 1;
    localparam int LK_OEN = 2;

    typedef enum logic [ADR_W-1:0] {
        OFS_REV  = 3'd0,
        OFS_CTL  = 3'd1,
        OFS_ACT  = 3'd2,
        OFS_SHD  = 3'd3,
        OFS_OEN  = 3'd4,
        OFS_LCK  = 3'd5,
        OFS_TRM  = 3'd6,
        OFS_NONE = 3'd7
    } ofs_e;

    typedef struct packed {
        logic [SEL_W-1:0] sync_sel;
        logic             load_on_sync;
        logic             gain2;
        logic             ref_alt;
    } ctl_t;

    // Control word as seen on the bus; bit 3 and the upper byte are zero.
    function automatic logic [BUS_W-1:0] ctl_image(input ctl_t c);
        return {{(BUS_W-8){1'b0}}, c.sync_sel, 1'b0, c.load_on_sync, c.gain2, c.ref_alt};
    endfunction

    // Byte-lane merge for a 12-bit field: lane 0 owns bits 7:0, lane 1 the rest.
    function automatic logic [CODE_W-1:0] put_lanes(input logic [CODE_W-1:0] old_v,
                                                    input logic [CODE_W-1:0] new_v,
                                                    input logic [BE_W-1:0]   be);
        logic [CODE_W-1:0] r;
        r = old_v;
        if (be[0]) r[7:0] = new_v[7:0];
        if (be[1]) r[CODE_W-1:8] = new_v[CODE_W-1:8];
        return r;
    endfunction

endpackage

// File: rtl/dacreg_lock.sv
module dacreg_lock
    import dacreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic              prot_en,
    input  logic              wr_full,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [LOCK_W-1:0] wr_bits,
    output logic [LOCK_W-1:0] lock_q,
    output logic              drop
);
    logic accept;

    assign accept = wr_hit && prot_en && wr_full && (wr_key == LOCK_KEY);
    assign drop   = wr_hit && !prot_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
        end else if (accept) begin
            lock_q <= lock_q | wr_bits;
        end
    end
endmodule

// File: rtl/dacreg_load.sv
module dacreg_load
    import dacreg_pkg::*;
#(
    parameter int NUM_SYNC = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shd_wr,
    input  logic [CODE_W-1:0]   wr_code,
    input  logic [BE_W-1:0]     wr_be,
    input  logic                load_on_sync,
    input  logic [SEL_W-1:0]    sync_sel,
    input  logic [NUM_SYNC-1:0] sync_pulse,
    output logic [CODE_W-1:0]   shadow_q,
    output logic [CODE_W-1:0]   active_q
);
    localparam int SEL_N = 1 << SEL_W;

    logic [SEL_N-1:0] sync_ext;
    logic             load_evt;

    // Select values with no source behind them see a constant zero.
    for (genvar g = 0; g < SEL_N; g++) begin : g_ext
        if (g < NUM_SYNC) begin : g_live
            assign sync_ext[g] = sync_pulse[g];
        end else begin : g_dead
            assign sync_ext[g] = 1'b0;
        end
    end

    assign load_evt = !load_on_sync || sync_ext[sync_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (shd_wr) shadow_q <= put_lanes(shadow_q, wr_code, wr_be);
            if (load_evt) active_q <= shadow_q;
        end
    end
endmodule

// File: rtl/dacreg_rdmux.sv
module dacreg_rdmux
    import dacreg_pkg::*;
#(
    parameter logic [7:0] REV_ID = 8'h00
) (
    input  logic [ADR_W-1:0]          rd_addr,
    input  ctl_t                      ctl,
    input  logic [CODE_W-1:0]         active,
    input  logic [CODE_W-1:0]         shadow,
    input  logic                      oen,
    input  logic [LOCK_W-1:0]         lock,
    input  logic [TRIM_W+SPARE_W-1:0] trim,
    output logic [BUS_W-1:0]          rdata
);
    always_comb begin
        rdata = '0;
        case (rd_addr)
            OFS_REV: rdata[7:0]                  = REV_ID;
            OFS_CTL: rdata                       = ctl_image(ctl);
            OFS_ACT: rdata[CODE_W-1:0]           = active;
            OFS_SHD: rdata[CODE_W-1:0]           = shadow;
            OFS_OEN: rdata[0]                    = oen;
            OFS_LCK: rdata[LOCK_W-1:0]           = lock;
            OFS_TRM: rdata[TRIM_W+SPARE_W-1:0]   = trim;
            default: rdata                       = '0;
        endcase
    end
endmodule

// File: rtl/dacreg_top.sv
module dacreg_top
    import dacreg_pkg::*;
#(
    parameter int         NUM_SYNC = 8,
    parameter logic [7:0] REV_ID   = 8'h00
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    input  logic                bus_we,
    input  logic [BE_W-1:0]     bus_be,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                prot_en,
    input  logic [NUM_SYNC-1:0] sync_pulse,
    output logic [CODE_W-1:0]   dac_code,
    output logic                dac_out_en,
    output logic                dac_gain2,
    output logic                dac_ref_alt,
    output logic [TRIM_W-1:0]   dac_trim,
    output logic                bus_err
);
    localparam int TRM_W = TRIM_W + SPARE_W;

    ctl_t              ctl_q;
    logic              oen_q;
    logic [TRM_W-1:0]  trim_q;
    logic              err_q;
    logic [LOCK_W-1:0] lock_q;
    logic [CODE_W-1:0] shadow_q;
    logic [CODE_W-1:0] active_q;
    logic              lock_drop;

    logic wr_ctl, wr_shd, wr_oen, wr_lck, wr_trm;
    logic ok_ctl, ok_shd, ok_oen, ok_trm;
    logic drop_any;

    assign wr_ctl = bus_we && (bus_addr == OFS_CTL);
    assign wr_shd = bus_we && (bus_addr == OFS_SHD);
    assign wr_oen = bus_we && (bus_addr == OFS_OEN);
    assign wr_lck = bus_we && (bus_addr == OFS_LCK);
    assign wr_trm = bus_we && (bus_addr == OFS_TRM);

    assign ok_ctl = wr_ctl && prot_en && !lock_q[LK_CTL];
    assign ok_shd = wr_shd && !lock_q[LK_SHD];
    assign ok_oen = wr_oen && prot_en && !lock_q[LK_OEN];
    assign ok_trm = wr_trm && prot_en;

    assign drop_any = (wr_ctl && !ok_ctl) || (wr_shd && !ok_shd) ||
                      (wr_oen && !ok_oen) || (wr_trm && !ok_trm) || lock_drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            oen_q  <= 1'b0;
            trim_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (ok_ctl && bus_be[0]) begin
                ctl_q <= '{sync_sel: bus_wdata[7:4], load_on_sync: bus_wdata[2],
                           gain2: bus_wdata[1], ref_alt: bus_wdata[0]};
            end
            if (ok_oen && bus_be[0]) oen_q <= bus_wdata[0];
            if (ok_trm) trim_q <= put_lanes(trim_q, bus_wdata[TRM_W-1:0], bus_be);
            err_q <= drop_any;
        end
    end

    dacreg_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_lck),
        .prot_en (prot_en),
        .wr_full (&bus_be),
        .wr_key  (bus_wdata[BUS_W-1 -: KEY_W]),
        .wr_bits (bus_wdata[LOCK_W-1:0]),
        .lock_q  (lock_q),
        .drop    (lock_drop)
    );

    dacreg_load #(.NUM_SYNC(NUM_SYNC)) u_load (
        .clk          (clk),
        .rst          (rst),
        .shd_wr       (ok_shd),
        .wr_code      (bus_wdata[CODE_W-1:0]),
        .wr_be        (bus_be),
        .load_on_sync (ctl_q.load_on_sync),
        .sync_sel     (ctl_q.sync_sel),
        .sync_pulse   (sync_pulse),
        .shadow_q     (shadow_q),
        .active_q     (active_q)
    );

    dacreg_rdmux #(.REV_ID(REV_ID)) u_rd (
        .rd_addr (bus_addr),
        .ctl     (ctl_q),
        .active  (active_q),
        .shadow  (shadow_q),
        .oen     (oen_q),
        .lock    (lock_q),
        .trim    (trim_q),
        .rdata   (bus_rdata)
    );

    assign dac_code    = active_q;
    assign dac_out_en  = oen_q;
    assign dac_gain2   = ctl_q.gain2;
    assign dac_ref_alt = ctl_q.ref_alt;
    assign dac_trim    = trim_q[TRIM_W-1:0];
    assign bus_err     = err_q;
endmodule

// File: rtl/dacreg_chk.sv
module dacreg_chk
    import dacreg_pkg::*;
#(
    parameter int NUM_SYNC = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                prot_en,
    input logic                bus_we,
    input logic [ADR_W-1:0]    bus_addr,
    input logic [NUM_SYNC-1:0] sync_pulse,
    input logic [CODE_W-1:0]   dac_code,
    input logic                bus_err,
    input ctl_t                ctl,
    input logic [CODE_W-1:0]   shadow,
    input logic [LOCK_W-1:0]   lock
);
    logic hit;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_SYNC; i++) begin
            if (int'(ctl.sync_sel) == i) hit = sync_pulse[i];
        end
    end

    a_r3_immediate_load: assert property (@(posedge clk) disable iff (rst)
        !ctl.load_on_sync |=> dac_code == $past(shadow));

    a_r4_hold_without_event: assert property (@(posedge clk) disable iff (rst)
        (ctl.load_on_sync && !hit) |=> $stable(dac_code));

    a_r4_take_on_event: assert property (@(posedge clk) disable iff (rst)
        (ctl.load_on_sync && hit) |=> dac_code == $past(shadow));

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (|lock) |=> ((lock & $past(lock)) == $past(lock)));

    a_r9_ctl_protected: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_CTL && !prot_en) |=> $stable(ctl));

    a_r11_err_from_write: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_we));
endmodule

bind dacreg_top dacreg_chk #(.NUM_SYNC(NUM_SYNC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .prot_en    (prot_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .sync_pulse (sync_pulse),
    .dac_code   (dac_code),
    .bus_err    (bus_err),
    .ctl        (ctl_q),
    .shadow     (shadow_q),
    .lock       (lock_q)
);

// File: tb/test_dacreg_top.sv
module test_dacreg_top;
    localparam int NS = 6;
    localparam logic [7:0] REVV = 8'h5C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_be = '0;
    logic [15:0]   bus_rdata;
    logic          prot_en = 1'b0;
    logic [NS-1:0] sync_pulse = '0;
    logic [11:0]   dac_code;
    logic          dac_out_en, dac_gain2, dac_ref_alt, bus_err;
    logic [7:0]    dac_trim;

    int total = 0;
    int bad = 0;

    // model state
    logic [7:0]  m_ctl;
    logic [11:0] m_shd, m_act, m_trim;
    logic        m_oen, m_err;
    logic [2:0]  m_lock;

    always #4 clk = ~clk;

    dacreg_top #(.NUM_SYNC(NS), .REV_ID(REVV)) i_dacreg_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_be(bus_be), .bus_rdata(bus_rdata), .prot_en(prot_en),
        .sync_pulse(sync_pulse), .dac_code(dac_code), .dac_out_en(dac_out_en),
        .dac_gain2(dac_gain2), .dac_ref_alt(dac_ref_alt), .dac_trim(dac_trim),
        .bus_err(bus_err)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {8'h00, REVV};
            3'd1: return {8'h00, m_ctl};
            3'd2: return {4'h0, m_act};
            3'd3: return {4'h0, m_shd};
            3'd4: return {15'h0, m_oen};
            3'd5: return {13'h0, m_lock};
            3'd6: return {4'h0, m_trim};
            default: return 16'h0000;
        endcase
    endfunction

    // Next state from the requirements, using the inputs present at the edge.
    task automatic model_edge();
        logic ld, er;
        int sel;
        sel = int'(m_ctl[7:4]);
        ld = !m_ctl[2] || (sel < NS && sync_pulse[sel]);
        er = 1'b0;
        if (ld) m_act = m_shd;
        if (bus_we) begin
            case (bus_addr)
                3'd1: if (prot_en && !m_lock[0]) begin
                          if (bus_be[0]) m_ctl = {bus_wdata[7:4], 1'b0, bus_wdata[2:0]};
                      end else er = 1'b1;
                3'd3: if (!m_lock[1]) begin
                          if (bus_be[0]) m_shd[7:0] = bus_wdata[7:0];
                          if (bus_be[1]) m_shd[11:8] = bus_wdata[11:8];
                      end else er = 1'b1;
                3'd4: if (prot_en && !m_lock[2]) begin
                          if (bus_be[0]) m_oen = bus_wdata[0];
                      end else er = 1'b1;
                3'd5: if (prot_en) begin
                          if (bus_be == 2'b11 && bus_wdata[15:12] == 4'hA)
                              m_lock = m_lock | bus_wdata[2:0];
                      end else er = 1'b1;
                3'd6: if (prot_en) begin
                          if (bus_be[0]) m_trim[7:0] = bus_wdata[7:0];
                          if (bus_be[1]) m_trim[11:8] = bus_wdata[11:8];
                      end else er = 1'b1;
                default: ;
            endcase
        end
        m_err = er;
    endtask

    task automatic drive(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be,
                         input logic we, input logic pe, input logic [NS-1:0] sp);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = we; prot_en = pe; sync_pulse = sp;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        chk("R3/R4 active code", {4'h0, dac_code}, {4'h0, m_act});
        chk("R11 bus_err", {15'h0, bus_err}, {15'h0, m_err});
        chk("R12 outputs", {4'h0, dac_trim, dac_out_en, dac_gain2, dac_ref_alt, 1'b0},
            {4'h0, m_trim[7:0], m_oen, m_ctl[1], m_ctl[0], 1'b0});
        chk("R2 read data", bus_rdata, exp_rd(bus_addr));
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
        drive(a, d, be, 1'b1, 1'b1, '0);
        step();
    endtask

    task automatic idle(input logic [NS-1:0] sp);
        drive(3'd2, 16'h0, 2'b00, 1'b0, 1'b1, sp);
        step();
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        drive(a, 16'h0, 2'b00, 1'b0, 1'b1, '0);
        step();
        chk(tag, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_we = 1'b0; bus_be = '0; bus_addr = '0; bus_wdata = '0;
        prot_en = 1'b0; sync_pulse = '0;
        repeat (3) @(posedge clk);
        m_ctl = '0; m_shd = '0; m_act = '0; m_trim = '0; m_oen = 1'b0; m_err = 1'b0; m_lock = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20515));
        do_reset();

        // R1: reset state
        #1;
        chk("R1 outputs after reset", {dac_code, dac_out_en, dac_gain2, dac_ref_alt, bus_err},
            16'h0000);
        chk("R1 trim after reset", {8'h0, dac_trim}, 16'h0000);
        rd(3'd0, 16'h005C, "R1 revision");
        for (int a = 1; a < 8; a++) rd(3'(a), 16'h0000, "R1 register zero");

        // R2: control layout, bit 3 reads zero
        wr(3'd1, 16'hFFFF, 2'b01);
        rd(3'd1, 16'h00F7, "R2 control layout");
        wr(3'd1, 16'h0000, 2'b01);

        // R3: immediate load, one cycle after shadow write
        wr(3'd3, 16'hFABC, 2'b11);
        chk("R3 active not yet updated", {4'h0, dac_code}, 16'h0000);
        idle('0);
        chk("R3 active follows shadow", {4'h0, dac_code}, 16'h0ABC);
        rd(3'd3, 16'h0ABC, "R2 shadow upper bits zero");

        // R10: byte strobes
        wr(3'd3, 16'h0123, 2'b10);
        rd(3'd3, 16'h01BC, "R10 upper lane only");
        wr(3'd1, 16'h00FF, 2'b10);
        rd(3'd1, 16'h0000, "R10 control needs lane 0");

        // R4: sync load with source 3
        wr(3'd1, 16'h0034, 2'b01);
        wr(3'd3, 16'h0777, 2'b11);
        repeat (3) idle(6'b110111);
        chk("R4 no load without selected pulse", {4'h0, dac_code}, 16'h01BC);
        idle(6'b001000);
        chk("R4 load on selected pulse", {4'h0, dac_code}, 16'h0777);

        // R6: write and load on the same edge
        wr(3'd3, 16'h0222, 2'b11);
        drive(3'd3, 16'h0555, 2'b11, 1'b1, 1'b1, 6'b001000);
        step();
        chk("R6 old shadow taken", {4'h0, dac_code}, 16'h0222);
        idle(6'b001000);
        chk("R6 new shadow at next event", {4'h0, dac_code}, 16'h0555);

        // R5: select beyond the sources present
        wr(3'd1, 16'h0074, 2'b01);
        wr(3'd3, 16'h0999, 2'b11);
        repeat (3) idle(6'b111111);
        chk("R5 select 7 never loads", {4'h0, dac_code}, 16'h0555);
        wr(3'd1, 16'h00F4, 2'b01);
        repeat (2) idle(6'b111111);
        chk("R5 select 15 never loads", {4'h0, dac_code}, 16'h0555);
        wr(3'd1, 16'h0064, 2'b01);
        repeat (2) idle(6'b111111);
        chk("R5 select 6 never loads", {4'h0, dac_code}, 16'h0555);
        wr(3'd1, 16'h0054, 2'b01);
        idle(6'b100000);
        chk("R4 last source loads", {4'h0, dac_code}, 16'h0999);

        // R12: outputs
        wr(3'd1, 16'h0003, 2'b01);
        wr(3'd4, 16'h0001, 2'b01);
        wr(3'd6, 16'h0A5C, 2'b11);
        #1;
        chk("R12 out enable", {15'h0, dac_out_en}, 16'h0001);
        chk("R12 gain and ref", {14'h0, dac_gain2, dac_ref_alt}, 16'h0003);
        chk("R12 trim", {8'h0, dac_trim}, 16'h005C);
        rd(3'd6, 16'h0A5C, "R2 trim with spare field");

        // R9 / R11: protected writes
        drive(3'd6, 16'h0F3C, 2'b11, 1'b1, 1'b0, '0);
        step();
        chk("R9 trim kept", {8'h0, dac_trim}, 16'h005C);
        chk("R11 error pulse", {15'h0, bus_err}, 16'h0001);
        idle('0);
        chk("R11 error single cycle", {15'h0, bus_err}, 16'h0000);
        drive(3'd3, 16'h0345, 2'b11, 1'b1, 1'b0, '0);
        step();
        chk("R9 shadow needs no enable", {15'h0, bus_err}, 16'h0000);
        idle('0);
        chk("R9 shadow loaded", {4'h0, dac_code}, 16'h0345);

        // R7: keyed lock writes
        wr(3'd5, 16'hB007, 2'b11);
        chk("R7 wrong key no error", {15'h0, bus_err}, 16'h0000);
        rd(3'd5, 16'h0000, "R7 wrong key ignored");
        wr(3'd5, 16'hA007, 2'b01);
        rd(3'd5, 16'h0000, "R7 partial write ignored");
        drive(3'd5, 16'hA007, 2'b11, 1'b1, 1'b0, '0);
        step();
        chk("R9 lock needs enable", {15'h0, bus_err}, 16'h0001);
        rd(3'd5, 16'h0000, "R7 unprotected lock write ignored");
        wr(3'd5, 16'hA002, 2'b11);
        rd(3'd5, 16'h0002, "R7 lock bit set, key reads zero");

        // R8: sticky locks
        wr(3'd5, 16'hA000, 2'b11);
        rd(3'd5, 16'h0002, "R8 zero does not clear");
        wr(3'd3, 16'h0FFF, 2'b11);
        chk("R8 locked shadow error", {15'h0, bus_err}, 16'h0001);
        rd(3'd3, 16'h0345, "R8 shadow locked");
        wr(3'd1, 16'h0000, 2'b01);
        rd(3'd1, 16'h0000, "R8 control still open");
        wr(3'd5, 16'hA005, 2'b11);
        rd(3'd5, 16'h0007, "R8 all locks set");
        wr(3'd1, 16'h0003, 2'b01);
        rd(3'd1, 16'h0000, "R8 control locked");
        wr(3'd4, 16'h0000, 2'b01);
        rd(3'd4, 16'h0001, "R8 out enable locked");

        do_reset();
        rd(3'd5, 16'h0000, "R1 reset clears locks");
        rd(3'd4, 16'h0000, "R1 reset clears enable");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] d;
            logic [NS-1:0] sp;
            d = 16'($urandom);
            if ($urandom % 4 == 0) d[15:12] = 4'hA;
            sp = ($urandom % 3 == 0) ? NS'($urandom) : '0;
            drive(3'($urandom), d, 2'($urandom), ($urandom % 3) != 0, ($urandom % 4) != 0, sp);
            step();
            if (n == 2000) do_reset();
        end

        finish_run();
    end
endmodule